// File: doc/BRIEF.md
# Mode-Aware Window Watchdog

This block supervises the microcontroller on behalf of a system basis chip mode controller. In Normal mode it runs a window watchdog. Each period is split into two halves. In the first half a clear is forbidden. In the second half a clear is accepted and starts a new period. A forbidden clear, or a period that ends with no clear at all, raises a one-cycle reset request toward the microcontroller.

In Normal Request mode the window logic is idle. A separate fixed timeout runs instead, and it also raises the reset request when it expires. The mode controller then takes the chip through Reset mode and back into Normal Request mode.

While the chip sits in Reset mode, the block samples a configuration-detect code from the analog front end:

- **External resistor found:** the watchdog uses the precise resistor timebase.
- **Pin tied to ground:** the watchdog is disabled for Normal mode.
- **Nothing detected:** the watchdog falls back to an internal default timebase and reports a fault.

A two-bit prescaler multiplies the selected base period by 1, 2, 4 or 8. All tick counts are parameters. The defaults are scaled down so that a simulation stays short.

Top module: `mode_window_wdog`

## Requirements
- R1: The window counter runs only while `mode_i` is 2'b10 (Normal). The other codes are 2'b00 Reset, 2'b01 Normal Request and 2'b11 low power. In any mode other than Normal, `clear_i` has no effect, and the counter restarts from zero on every entry into Normal mode.
- R2: Number the rising edges that sample Normal mode 1, 2, 3 and so on, and let P be the period. A clear sampled at edge k with k <= P/2 falls in the closed window. It drives `mcu_rst_o` high during the cycle after edge k.
- R3: A clear sampled at edge k with P/2 < k <= P falls in the open window. It produces no reset request and restarts the period, so that with no further clear the next overflow occurs at edge k+P.
- R4: If no clear arrives, `mcu_rst_o` goes high for exactly one cycle after edge P, and the period then restarts.
- R5: In Normal Request mode (2'b01), the timeout drives `mcu_rst_o` high during the cycle after the NRQ_TICKS-th consecutive edge that samples that mode. Clears are ignored in this mode.
- R6: If `cfg_code_i` is 2'b10 (pin tied to ground) while in Reset mode, `wd_off_o` is set. Normal mode then never produces a reset request, whatever the clears.
- R7: If `cfg_code_i` is 2'b00 or 2'b11 (nothing detected) while in Reset mode, `tb_fault_o` is set and the base period is INT_TICKS. If the code is 2'b01 (resistor found), both status bits clear and the base period is RES_TICKS.
- R8: The period is the base period shifted left by `presc_i`, that is, multiplied by 1, 2, 4 or 8.
- R9: `cfg_code_i` is sampled only while in Reset mode. Changes made in any other mode leave `wd_off_o` and `tb_fault_o` unchanged.
- R10: While `rst_ni` is low, `mcu_rst_o`, `wd_off_o` and `tb_fault_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Current operating mode code |
| clear_i | input | 1 | Watchdog clear strobe from the register interface |
| cfg_code_i | input | 2 | Configuration-detect code |
| presc_i | input | PRESC_W | Period prescaler select |
| mcu_rst_o | output | 1 | One-cycle reset request to the microcontroller |
| wd_off_o | output | 1 | Watchdog disabled status |
| tb_fault_o | output | 1 | Fallback-timebase status |

## Verification
The assertions rely on the surrounding mode controller for two things:

- `mode_i` stays stable for at least one clock between changes.
- `cfg_code_i` is valid whenever Reset mode is sampled.

The property that forbids two reset sources at once also relies on only one mode code being active per cycle. The stimulus respects all of this: it changes `mode_i`, `clear_i` and `presc_i` only on falling edges, it holds each mode for several cycles, and it changes the prescaler only outside Normal mode. The one exception is a deliberate change of the detect code during Normal mode, which is there to exercise R9.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic [1:0] {
      MODE_RST  = 2'b00,
      MODE_NREQ = 2'b01,
      MODE_NORM = 2'b10,
      MODE_LOWP = 2'b11
   } op_mode_e;

   localparam logic [1:0] CFG_RESISTOR = 2'b01;
   localparam logic [1:0] CFG_GROUNDED = 2'b10;
endpackage

// File: rtl/wdog_cfg_latch.sv
module wdog_cfg_latch
   import wdog_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       in_reset_i,
   input  logic [1:0] cfg_code_i,
   output logic       off_o,
   output logic       fault_o
);
   logic off_q, fault_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         off_q   <= 1'b0;
         fault_q <= 1'b0;
      end else if (in_reset_i) begin
         off_q   <= (cfg_code_i == CFG_GROUNDED);
         fault_q <= (cfg_code_i != CFG_GROUNDED) && (cfg_code_i != CFG_RESISTOR);
      end
   end

   assign off_o   = off_q;
   assign fault_o = fault_q;

   // R9
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_reset_i |=> $stable({off_q, fault_q}));

   // R6
   cfg_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(off_q && fault_q));
endmodule

// File: rtl/wdog_period_sel.sv
module wdog_period_sel #(
   parameter int RES_TICKS = 16,
   parameter int INT_TICKS = 24,
   parameter int PRESC_W   = 2,
   parameter int PER_W     = 8
) (
   input  logic               fault_i,
   input  logic [PRESC_W-1:0] presc_i,
   output logic [PER_W-1:0]   period_o,
   output logic [PER_W-1:0]   half_o
);
   localparam int NSEL = 1 << PRESC_W;

   if (RES_TICKS < 2 || (RES_TICKS % 2) != 0) begin : g_bad_res
      $error("RES_TICKS must be even and at least 2");
   end
   if (INT_TICKS < 2 || (INT_TICKS % 2) != 0) begin : g_bad_int
      $error("INT_TICKS must be even and at least 2");
   end
   if (PRESC_W < 1 || PRESC_W > 4) begin : g_bad_presc
      $error("PRESC_W must lie in 1..4");
   end

   logic [PER_W-1:0] res_tab [NSEL];
   logic [PER_W-1:0] int_tab [NSEL];

   for (genvar s = 0; s < NSEL; s++) begin : g_scale
      assign res_tab[s] = PER_W'(RES_TICKS << s);
      assign int_tab[s] = PER_W'(INT_TICKS << s);
   end

   always_comb begin
      period_o = fault_i ? int_tab[presc_i] : res_tab[presc_i];
      half_o   = period_o >> 1;
   end
endmodule

// File: rtl/wdog_window_ctr.sv
module wdog_window_ctr #(
   parameter int PER_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             clear_i,
   input  logic [PER_W-1:0] period_i,
   input  logic [PER_W-1:0] half_i,
   output logic             req_o
);
   logic [PER_W-1:0] cnt_q;
   logic             req_q;
   logic             closed, last;

   always_comb begin
      closed = (cnt_q < half_i);
      last   = (cnt_q >= period_i - PER_W'(1));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (!run_i) begin
            cnt_q <= '0;
         end else if (clear_i) begin
            cnt_q <= '0;
            req_q <= closed;
         end else if (last) begin
            cnt_q <= '0;
            req_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + PER_W'(1);
         end
      end
   end

   assign req_o = req_q;

   // R1
   win_idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (!req_q && cnt_q == '0));

   // R4
   win_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q |-> (cnt_q == '0));
endmodule

// File: rtl/wdog_timeout_ctr.sv
module wdog_timeout_ctr #(
   parameter int TICKS = 40
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic req_o
);
   localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

   if (TICKS < 2) begin : g_bad_ticks
      $error("TICKS must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          req_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (!run_i) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(TICKS - 1)) begin
            cnt_q <= '0;
            req_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign req_o = req_q;

   // R5
   to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (!req_q && cnt_q == '0));
endmodule

// File: rtl/mode_window_wdog.sv
module mode_window_wdog
   import wdog_pkg::*;
#(
   parameter int RES_TICKS = 16,
   parameter int INT_TICKS = 24,
   parameter int NRQ_TICKS = 40,
   parameter int PRESC_W   = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [1:0]         mode_i,
   input  logic               clear_i,
   input  logic [1:0]         cfg_code_i,
   input  logic [PRESC_W-1:0] presc_i,
   output logic               mcu_rst_o,
   output logic               wd_off_o,
   output logic               tb_fault_o
);
   localparam int BASE_MAX = (RES_TICKS > INT_TICKS) ? RES_TICKS : INT_TICKS;
   localparam int PER_MAX  = BASE_MAX << ((1 << PRESC_W) - 1);
   localparam int PER_W    = $clog2(PER_MAX + 1);

   op_mode_e         mode;
   logic             off, fault;
   logic             run_win, run_to;
   logic             win_req, to_req;
   logic [PER_W-1:0] period, half;

   assign mode    = op_mode_e'(mode_i);
   assign run_win = (mode == MODE_NORM) && !off;
   assign run_to  = (mode == MODE_NREQ);

   wdog_cfg_latch u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_reset_i (mode == MODE_RST),
      .cfg_code_i (cfg_code_i),
      .off_o      (off),
      .fault_o    (fault)
   );

   wdog_period_sel #(
      .RES_TICKS (RES_TICKS),
      .INT_TICKS (INT_TICKS),
      .PRESC_W   (PRESC_W),
      .PER_W     (PER_W)
   ) u_per (
      .fault_i  (fault),
      .presc_i  (presc_i),
      .period_o (period),
      .half_o   (half)
   );

   wdog_window_ctr #(.PER_W(PER_W)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_win),
      .clear_i  (clear_i),
      .period_i (period),
      .half_i   (half),
      .req_o    (win_req)
   );

   wdog_timeout_ctr #(.TICKS(NRQ_TICKS)) u_nrq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_to),
      .req_o  (to_req)
   );

   assign mcu_rst_o  = win_req | to_req;
   assign wd_off_o   = off;
   assign tb_fault_o = fault;

   // R4
   rst_src_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({win_req, to_req}));

   // R6
   off_no_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off |=> !win_req);
endmodule

// File: tb/mode_window_wdog_tb_top.sv
`timescale 1ns/1ps
module mode_window_wdog_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       clear = 1'b0;
   logic [1:0] cfg = 2'b01;
   logic [1:0] presc = 2'b00;
   logic       mcu_rst, wd_off, tb_fault;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int c0 = 0;
   int pulses = 0;
   bit done = 1'b0;
   int   exp_q[$];
   string tag_q[$];

   localparam logic [1:0] M_RST = 2'b00, M_NRQ = 2'b01, M_NORM = 2'b10, M_LOWP = 2'b11;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mode_window_wdog dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .clear_i(clear),
      .cfg_code_i(cfg), .presc_i(presc), .mcu_rst_o(mcu_rst),
      .wd_off_o(wd_off), .tb_fault_o(tb_fault)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic go_mode(input logic [1:0] m);
      @(negedge clk);
      mode = m;
      c0 = cyc;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // clear sampled at edge k after the last mode change
   task automatic clear_at(input int k);
      while (cyc < c0 + k - 1) @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
   endtask

   task automatic expect_pulse(input int k, input string tag);
      exp_q.push_back(c0 + k);
      tag_q.push_back(tag);
   endtask

   // monitor: compares each reset pulse against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mcu_rst) begin
            pulses++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "unexpected reset pulse", cyc, -1);
            end else begin
               int e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(cyc == e, t, cyc, e);
            end
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int p0;
      // R10 reset state
      idle(3);
      chk(mcu_rst == 1'b0, "R10 reset mcu_rst", mcu_rst, 0);
      chk(wd_off == 1'b0, "R10 reset wd_off", wd_off, 0);
      chk(tb_fault == 1'b0, "R10 reset tb_fault", tb_fault, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      chk(wd_off == 1'b0 && tb_fault == 1'b0, "R7 resistor status clear",
          {wd_off, tb_fault}, 0);

      // R4 overflow at edge 16
      go_mode(M_NORM);
      expect_pulse(16, "R4 overflow pulse");
      idle(17);
      chk(mcu_rst == 1'b0, "R4 pulse one cycle", mcu_rst, 0);
      go_mode(M_RST); idle(2);

      // R2 closed-window clear at edge 8
      go_mode(M_NORM);
      expect_pulse(8, "R2 closed clear");
      clear_at(8);
      idle(3);
      go_mode(M_RST); idle(2);

      // R3 open-window clear at edge 9, then overflow at 25
      go_mode(M_NORM);
      p0 = pulses;
      clear_at(9);
      idle(3);
      chk(pulses == p0, "R3 open clear no pulse", pulses - p0, 0);
      expect_pulse(25, "R3 restart after open clear");
      while (cyc < c0 + 26) @(negedge clk);
      go_mode(M_RST); idle(2);

      // R3 clear at last edge 16, overflow at 32
      go_mode(M_NORM);
      expect_pulse(32, "R3 clear at last edge");
      clear_at(16);
      while (cyc < c0 + 33) @(negedge clk);
      go_mode(M_RST); idle(2);

      // R1 clears in low-power and reset modes are ignored
      p0 = pulses;
      go_mode(M_LOWP);
      clear_at(3); clear_at(10);
      idle(30);
      go_mode(M_RST);
      clear_at(2);
      idle(5);
      chk(pulses == p0, "R1 clears outside Normal ignored", pulses - p0, 0);

      // R1 re-entry restarts counter
      go_mode(M_NORM);
      idle(10);
      go_mode(M_LOWP);
      idle(2);
      go_mode(M_NORM);
      expect_pulse(16, "R1 counter restarts on entry");
      idle(18);
      go_mode(M_RST); idle(2);

      // R5 Normal Request timeout, clears ignored
      go_mode(M_NRQ);
      expect_pulse(40, "R5 normal request timeout");
      clear_at(5); clear_at(30);
      idle(12);
      go_mode(M_RST); idle(2);

      // R8 prescaler: presc=2 -> period 64, half 32
      presc = 2'd2;
      go_mode(M_NORM);
      expect_pulse(32, "R8 closed clear at 32 with presc 2");
      clear_at(32);
      idle(2);
      go_mode(M_RST); idle(2);
      go_mode(M_NORM);
      expect_pulse(97, "R8 open clear at 33 then period 64");
      clear_at(33);
      while (cyc < c0 + 98) @(negedge clk);
      go_mode(M_RST); idle(2);
      presc = 2'd1;
      go_mode(M_NORM);
      expect_pulse(32, "R8 presc 1 overflow");
      idle(34);
      go_mode(M_RST);
      presc = 2'd0;

      // R7 nothing detected -> fallback timebase 24
      cfg = 2'b00;
      idle(2);
      chk(tb_fault == 1'b1, "R7 fault set", tb_fault, 1);
      chk(wd_off == 1'b0, "R7 wd_off stays clear", wd_off, 0);
      go_mode(M_NORM);
      expect_pulse(24, "R7 fallback overflow");
      idle(12);

      // R9 detect code changed outside Reset mode
      cfg = 2'b10;
      idle(14);
      chk(wd_off == 1'b0, "R9 wd_off unchanged", wd_off, 0);
      chk(tb_fault == 1'b1, "R9 tb_fault unchanged", tb_fault, 1);
      go_mode(M_RST); idle(2);

      // R6 grounded -> disabled
      chk(wd_off == 1'b1, "R6 wd_off set", wd_off, 1);
      chk(tb_fault == 1'b0, "R6 tb_fault clear", tb_fault, 0);
      p0 = pulses;
      go_mode(M_NORM);
      clear_at(3); clear_at(20);
      idle(100);
      chk(pulses == p0, "R6 disabled watchdog silent", pulses - p0, 0);
      go_mode(M_RST); idle(2);

      chk(exp_q.size() == 0, "all expected pulses seen", exp_q.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule